// File: doc/BRIEF.md
# Remote-Power Discovery Sequencer

This block is a host-side controller for one twisted-pair port that manages power delivery to a link partner which draws its supply over the cable. It talks to the port's PHY through a simple register access port. Each transaction is a read or write request that carries a register address and 16 data bits, and the PHY completes it with a one-cycle done pulse. The block also drives an enable for the external power supply feeding that port.

After reset the block arms discovery. It reads the control register to learn whether negotiation was already running, sets the discovery-enable bit, and enables negotiation, restarting it when needed. It then polls the PHY's powered-device flag at a programmable interval. When the flag reads 1 it switches the supply on and restarts negotiation, using either negotiation restart or a forced-speed write. It then watches link status.

If link is not confirmed within a run-time timeout, or if an established link later drops, the supply is switched off, discovery is re-armed and flag polling resumes. Sticky indications record that power was applied, that link was reached and that a timeout happened.

Top module: `pds_discovery_seq`

## Requirements
- R1: A synchronous active-low reset forces the supply enable low, the request low, all three sticky flags low and busy high. The first transaction after reset is a read of register 0.
- R2: Once raised, the request stays high with unchanged address, write flag and write data until the cycle in which done is seen. A new transaction may begin in the next cycle.
- R3: Initialization writes 0x0040 (bit 6, discovery enable) to register 27 and then writes register 0. The register 0 value is 0x1000 (bit 12, negotiation enable) when the initial read of register 0 had bit 12 clear. It is 0x1200 (bit 12 plus bit 9, negotiation restart) when that read had bit 12 set.
- R4: Register 4 is never written, so its next-page control bit 15 keeps its cleared default.
- R5: Register 27 is read repeatedly until bit 4 (powered-device flag) reads 1. Successive reads of register 27 start at least `cfg_poll_gap` cycles apart, and the supply enable stays low throughout.
- R6: The supply enable rises in the same cycle that a write to register 0 is launched. That write carries 0x1200 when `cfg_forced_mode` is 0 and the `FORCE_WORD` parameter (default 0x2100: 100 Mb/s, full duplex, negotiation off) when it is 1.
- R7: Link status is sampled by two back-to-back reads of register 1. Only bit 2 of the second read counts, so a stale latched-low value does not hide a link that is up.
- R8: If link has not been confirmed within `cfg_timeout` cycles of the supply enable rising, the supply enable falls and the sticky timeout flag sets. It falls no earlier than `cfg_timeout` cycles after rising. A link confirmed in time keeps the supply on.
- R9: While linked, register 1 keeps being polled in pairs. A second read with bit 2 at 0 drops the supply enable without setting the timeout flag.
- R10: Every supply removal is followed by a write of 0x1200 to register 0 and a return to polling register 27.
- R11: The sticky powered, link and timeout flags, once set, stay set until reset.
- R12: Busy is low only while the block waits out a poll interval, never while a request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_forced_mode | input | 1 | 1: restart after power-on by forced-speed write; 0: by negotiation restart |
| cfg_timeout | input | TMO_W | Link timeout after power-on, in cycles |
| cfg_poll_gap | input | GAP_W | Idle cycles between polls |
| mgmt_req | output | 1 | Register transaction request |
| mgmt_we | output | 1 | 1: write, 0: read |
| mgmt_addr | output | 5 | Register address |
| mgmt_wdata | output | 16 | Write data |
| mgmt_rdata | input | 16 | Read data, valid with done |
| mgmt_done | input | 1 | One-cycle transaction completion |
| psu_en | output | 1 | Power-supply enable for the link partner |
| busy | output | 1 | Low only during a poll interval wait |
| sticky_powered | output | 1 | Power has been applied since reset |
| sticky_link | output | 1 | Link has been confirmed since reset |
| sticky_timeout | output | 1 | A link timeout has removed power since reset |

## Verification
The hardest case to reach from the ports is the latched-low link bit. Link is physically up, yet the first read of register 1 still reports it down. Only a sequencer that trusts the second read of each pair catches the link in that same round. The bench PHY model keeps a latch that clears while link is down and reloads only on a read. It raises link between polls, so the first read after power-on always returns the stale 0. The timeout path is reached by leaving link low after the flag appears, and the window length is measured between the supply enable's edges.

// File: rtl/pds_pkg.sv
package pds_pkg;

    localparam int MGMT_AW = 5;
    localparam int MGMT_DW = 16;

    // register addresses the PHY decodes
    localparam logic [MGMT_AW-1:0] REG_CTRL   = 5'd0;
    localparam logic [MGMT_AW-1:0] REG_STATUS = 5'd1;
    localparam logic [MGMT_AW-1:0] REG_DISC   = 5'd27;

    // bit positions the PHY decodes
    localparam int BIT_AN_EN      = 12;
    localparam int BIT_AN_RESTART = 9;
    localparam int BIT_DISC_EN    = 6;
    localparam int BIT_PD_FLAG    = 4;
    localparam int BIT_LINK       = 2;

    localparam logic [MGMT_DW-1:0] WORD_DISC_ON = MGMT_DW'(1) << BIT_DISC_EN;
    localparam logic [MGMT_DW-1:0] WORD_AN_ON   = MGMT_DW'(1) << BIT_AN_EN;
    localparam logic [MGMT_DW-1:0] WORD_AN_KICK = WORD_AN_ON | (MGMT_DW'(1) << BIT_AN_RESTART);

    typedef enum logic [3:0] {
        ST_BOOT,
        ST_RD_CTRL,
        ST_WR_DISC,
        ST_WR_CTRL,
        ST_FLAG_GAP,
        ST_RD_FLAG,
        ST_RESTART,
        ST_LINK_GAP,
        ST_LINK_RD1,
        ST_LINK_RD2,
        ST_REARM
    } seq_state_e;

    typedef struct packed {
        logic               req;
        logic               we;
        logic [MGMT_AW-1:0] addr;
        logic [MGMT_DW-1:0] wdata;
    } mgmt_cmd_t;

    typedef struct packed {
        seq_state_e state;
        logic       an_prev;
        logic       linked;
        logic       psu;
        logic       st_pwr;
        logic       st_link;
        logic       st_tmo;
        logic       busy;
        mgmt_cmd_t  cmd;
    } seq_reg_t;

    // management command that a state presents while it is current
    function automatic mgmt_cmd_t cmd_for(input seq_state_e s, input logic an_prev,
                                          input logic forced, input logic [MGMT_DW-1:0] force_word);
        mgmt_cmd_t c;
        c = '0;
        case (s)
            ST_RD_CTRL:  begin c.req = 1'b1; c.addr = REG_CTRL; end
            ST_WR_DISC:  begin c.req = 1'b1; c.we = 1'b1; c.addr = REG_DISC; c.wdata = WORD_DISC_ON; end
            ST_WR_CTRL:  begin
                c.req = 1'b1; c.we = 1'b1; c.addr = REG_CTRL;
                c.wdata = an_prev ? WORD_AN_KICK : WORD_AN_ON;
            end
            ST_RD_FLAG:  begin c.req = 1'b1; c.addr = REG_DISC; end
            ST_RESTART:  begin
                c.req = 1'b1; c.we = 1'b1; c.addr = REG_CTRL;
                c.wdata = forced ? force_word : WORD_AN_KICK;
            end
            ST_LINK_RD1,
            ST_LINK_RD2: begin c.req = 1'b1; c.addr = REG_STATUS; end
            ST_REARM:    begin c.req = 1'b1; c.we = 1'b1; c.addr = REG_CTRL; c.wdata = WORD_AN_KICK; end
            default:     c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pds_counter.sv
module pds_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         stop_i,
    input  logic [W-1:0] limit_i,
    output logic         done_o
);
    logic [W-1:0] cnt_d, cnt_q;
    logic         run_d, run_q;

    assign done_o = run_q && (cnt_q >= limit_i);

    always_comb begin
        cnt_d = cnt_q;
        run_d = run_q;
        if (start_i) begin
            cnt_d = '0;
            run_d = 1'b1;
        end else if (stop_i) begin
            run_d = 1'b0;
        end else if (run_q && !done_o) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            run_q <= run_d;
        end
    end
endmodule

// File: rtl/pds_fsm.sv
module pds_fsm
    import pds_pkg::*;
#(
    parameter logic [MGMT_DW-1:0] FORCE_WORD = 16'h2100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_forced_mode,
    input  logic [MGMT_DW-1:0] mgmt_rdata,
    input  logic               mgmt_done,
    input  logic               gap_done,
    input  logic               tmo_done,
    output logic               gap_start,
    output logic               tmo_start,
    output logic               tmo_stop,
    output seq_reg_t           st_o
);
    seq_reg_t q, n;
    logic     drop, drop_tmo;

    always_comb begin
        n         = q;
        gap_start = 1'b0;
        tmo_start = 1'b0;
        tmo_stop  = 1'b0;
        drop      = 1'b0;
        drop_tmo  = 1'b0;

        case (q.state)
            ST_BOOT: n.state = ST_RD_CTRL;
            ST_RD_CTRL: if (mgmt_done) begin
                n.an_prev = mgmt_rdata[BIT_AN_EN];
                n.state   = ST_WR_DISC;
            end
            ST_WR_DISC: if (mgmt_done) n.state = ST_WR_CTRL;
            ST_WR_CTRL: if (mgmt_done) begin
                n.state   = ST_FLAG_GAP;
                gap_start = 1'b1;
            end
            ST_FLAG_GAP: if (gap_done) n.state = ST_RD_FLAG;
            ST_RD_FLAG: if (mgmt_done) begin
                if (mgmt_rdata[BIT_PD_FLAG]) begin
                    n.psu     = 1'b1;
                    n.st_pwr  = 1'b1;
                    n.linked  = 1'b0;
                    tmo_start = 1'b1;
                    n.state   = ST_RESTART;
                end else begin
                    n.state   = ST_FLAG_GAP;
                    gap_start = 1'b1;
                end
            end
            ST_RESTART: if (mgmt_done) begin
                n.state   = ST_LINK_GAP;
                gap_start = 1'b1;
            end
            ST_LINK_GAP: begin
                if (!q.linked && tmo_done) begin
                    drop     = 1'b1;
                    drop_tmo = 1'b1;
                end else if (gap_done) begin
                    n.state = ST_LINK_RD1;
                end
            end
            ST_LINK_RD1: if (mgmt_done) n.state = ST_LINK_RD2;
            ST_LINK_RD2: if (mgmt_done) begin
                if (mgmt_rdata[BIT_LINK]) begin
                    if (!q.linked) begin
                        n.linked  = 1'b1;
                        n.st_link = 1'b1;
                        tmo_stop  = 1'b1;
                    end
                    n.state   = ST_LINK_GAP;
                    gap_start = 1'b1;
                end else if (q.linked) begin
                    drop = 1'b1;
                end else if (tmo_done) begin
                    drop     = 1'b1;
                    drop_tmo = 1'b1;
                end else begin
                    n.state   = ST_LINK_GAP;
                    gap_start = 1'b1;
                end
            end
            ST_REARM: if (mgmt_done) begin
                n.state   = ST_FLAG_GAP;
                gap_start = 1'b1;
            end
            default: n.state = ST_BOOT;
        endcase

        if (drop) begin
            n.psu    = 1'b0;
            n.linked = 1'b0;
            tmo_stop = 1'b1;
            n.state  = ST_REARM;
            if (drop_tmo) n.st_tmo = 1'b1;
        end

        n.cmd  = cmd_for(n.state, n.an_prev, cfg_forced_mode, FORCE_WORD);
        n.busy = !(n.state == ST_FLAG_GAP || n.state == ST_LINK_GAP);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_BOOT;
            q.busy  <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign st_o = q;
endmodule

// File: rtl/pds_discovery_seq.sv
module pds_discovery_seq
    import pds_pkg::*;
#(
    parameter int                 TMO_W      = 32,
    parameter int                 GAP_W      = 16,
    parameter logic [MGMT_DW-1:0] FORCE_WORD = 16'h2100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_forced_mode,
    input  logic [TMO_W-1:0]   cfg_timeout,
    input  logic [GAP_W-1:0]   cfg_poll_gap,
    output logic               mgmt_req,
    output logic               mgmt_we,
    output logic [MGMT_AW-1:0] mgmt_addr,
    output logic [MGMT_DW-1:0] mgmt_wdata,
    input  logic [MGMT_DW-1:0] mgmt_rdata,
    input  logic               mgmt_done,
    output logic               psu_en,
    output logic               busy,
    output logic               sticky_powered,
    output logic               sticky_link,
    output logic               sticky_timeout
);
    seq_reg_t st;
    logic     gap_start, gap_done;
    logic     tmo_start, tmo_stop, tmo_done;

    pds_fsm #(.FORCE_WORD(FORCE_WORD)) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_forced_mode (cfg_forced_mode),
        .mgmt_rdata      (mgmt_rdata),
        .mgmt_done       (mgmt_done),
        .gap_done        (gap_done),
        .tmo_done        (tmo_done),
        .gap_start       (gap_start),
        .tmo_start       (tmo_start),
        .tmo_stop        (tmo_stop),
        .st_o            (st)
    );

    pds_counter #(.W(GAP_W)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (gap_start),
        .stop_i  (1'b0),
        .limit_i (cfg_poll_gap),
        .done_o  (gap_done)
    );

    pds_counter #(.W(TMO_W)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tmo_start),
        .stop_i  (tmo_stop),
        .limit_i (cfg_timeout),
        .done_o  (tmo_done)
    );

    assign mgmt_req       = st.cmd.req;
    assign mgmt_we        = st.cmd.we;
    assign mgmt_addr      = st.cmd.addr;
    assign mgmt_wdata     = st.cmd.wdata;
    assign psu_en         = st.psu;
    assign busy           = st.busy;
    assign sticky_powered = st.st_pwr;
    assign sticky_link    = st.st_link;
    assign sticky_timeout = st.st_tmo;
endmodule

// File: rtl/pds_discovery_seq_chk.sv
module pds_discovery_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mgmt_req,
    input logic        mgmt_we,
    input logic [4:0]  mgmt_addr,
    input logic [15:0] mgmt_wdata,
    input logic [15:0] mgmt_rdata,
    input logic        mgmt_done,
    input logic        psu_en,
    input logic        busy,
    input logic        sticky_powered,
    input logic        sticky_link,
    input logic        sticky_timeout
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> !psu_en && !mgmt_req && busy && !sticky_powered && !sticky_link && !sticky_timeout); // R1

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_req && !mgmt_done |=> mgmt_req && $stable(mgmt_we) && $stable(mgmt_addr) && $stable(mgmt_wdata)); // R2

    AST_NO_NEXT_PAGE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_req && mgmt_we |-> mgmt_addr != 5'd4); // R4

    AST_POWER_ON_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(psu_en) |-> $past(mgmt_done && mgmt_req && !mgmt_we && mgmt_addr == 5'd27 && mgmt_rdata[4])); // R5

    AST_RESTART_WITH_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(psu_en) |-> mgmt_req && mgmt_we && mgmt_addr == 5'd0); // R6

    AST_POWER_OFF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(psu_en) |-> sticky_timeout || $past(mgmt_done && !mgmt_we && mgmt_addr == 5'd1 && !mgmt_rdata[2])); // R9

    AST_REARM_AFTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(psu_en) |-> mgmt_req && mgmt_we && mgmt_addr == 5'd0 && mgmt_wdata == 16'h1200); // R10

    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(sticky_powered) && !$fell(sticky_link) && !$fell(sticky_timeout)); // R11

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mgmt_req); // R12
endmodule

bind pds_discovery_seq pds_discovery_seq_chk u_chk (.*);

// File: tb/pds_discovery_seq_bench.sv
`timescale 1ns/1ps
module pds_discovery_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_forced_mode = 1'b0;
    logic [31:0] cfg_timeout = 32'd400;
    logic [15:0] cfg_poll_gap = 16'd20;
    logic        mgmt_req, mgmt_we, psu_en, busy;
    logic [4:0]  mgmt_addr;
    logic [15:0] mgmt_wdata;
    logic [15:0] mgmt_rdata = 16'h0;
    logic        mgmt_done = 1'b0;
    logic        sticky_powered, sticky_link, sticky_timeout;

    always #4 clk = ~clk;

    pds_discovery_seq u_pds_discovery_seq (
        .clk(clk), .rst_n(rst_n), .cfg_forced_mode(cfg_forced_mode),
        .cfg_timeout(cfg_timeout), .cfg_poll_gap(cfg_poll_gap),
        .mgmt_req(mgmt_req), .mgmt_we(mgmt_we), .mgmt_addr(mgmt_addr),
        .mgmt_wdata(mgmt_wdata), .mgmt_rdata(mgmt_rdata), .mgmt_done(mgmt_done),
        .psu_en(psu_en), .busy(busy), .sticky_powered(sticky_powered),
        .sticky_link(sticky_link), .sticky_timeout(sticky_timeout)
    );

    int checks = 0, failures = 0, cyc = 0;
    bit finished = 1'b0;

    // PHY model state
    logic [15:0] m_reg0 = 16'h0, m_reg27 = 16'h0;
    logic        pd_flag = 1'b0, link_now = 1'b0, latch = 1'b0;
    logic        active = 1'b0, c_we;
    logic [4:0]  c_addr;
    logic [15:0] c_wdata;
    int          lat = 0;
    int          n_rd27 = 0, n_rd1 = 0, n_wr4 = 0, hs_err = 0;
    int          wr_n = 0, last_rd27 = -1, min_gap27 = 1000000;
    logic [4:0]  wr_addr [0:63];
    logic [15:0] wr_data [0:63];
    int          rise_cyc = 0, fall_cyc = 0, sticky_err = 0, busy_err = 0;
    bit          seen_idle = 1'b0;
    logic        psu_prev = 1'b0, sp_prev = 1'b0, sl_prev = 1'b0, st_prev = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // PHY model and monitors, sampling at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (!link_now) latch = 1'b0;
            if (rst_n) begin
                if (!busy) seen_idle = 1'b1;
                if (!busy && mgmt_req) busy_err++;
                if ((sp_prev && !sticky_powered) || (sl_prev && !sticky_link) || (st_prev && !sticky_timeout))
                    sticky_err++;
            end
            if (psu_en && !psu_prev) rise_cyc = cyc;
            if (!psu_en && psu_prev) fall_cyc = cyc;
            psu_prev = psu_en; sp_prev = sticky_powered; sl_prev = sticky_link; st_prev = sticky_timeout;
            if (!rst_n) begin
                mgmt_done = 1'b0;
                active = 1'b0;
            end else if (mgmt_done) begin
                mgmt_done = 1'b0;
            end else if (active) begin
                if (!mgmt_req || mgmt_addr != c_addr || mgmt_we != c_we || mgmt_wdata != c_wdata) hs_err++;
                lat--;
                if (lat == 0) begin
                    active = 1'b0;
                    mgmt_done = 1'b1;
                    if (c_we) begin
                        if (wr_n < 64) begin wr_addr[wr_n] = c_addr; wr_data[wr_n] = c_wdata; end
                        wr_n++;
                        if (c_addr == 5'd0) m_reg0 = c_wdata;
                        if (c_addr == 5'd27) m_reg27 = c_wdata;
                        if (c_addr == 5'd4) n_wr4++;
                    end else begin
                        case (c_addr)
                            5'd0:  mgmt_rdata = m_reg0;
                            5'd27: begin mgmt_rdata = {m_reg27[15:5], pd_flag, m_reg27[3:0]}; n_rd27++; end
                            5'd1:  begin mgmt_rdata = {13'h0, latch, 2'b00}; latch = link_now; n_rd1++; end
                            default: mgmt_rdata = 16'h0;
                        endcase
                    end
                end
            end else if (mgmt_req) begin
                active = 1'b1; lat = 2;
                c_we = mgmt_we; c_addr = mgmt_addr; c_wdata = mgmt_wdata;
                if (!mgmt_we && mgmt_addr == 5'd27) begin
                    if (last_rd27 >= 0 && cyc - last_rd27 < min_gap27) min_gap27 = cyc - last_rd27;
                    last_rd27 = cyc;
                end
            end
        end
    end

    task automatic do_reset(input logic [15:0] reg0_init);
        rst_n = 1'b0;
        m_reg0 = reg0_init; m_reg27 = 16'h0;
        wr_n = 0; n_rd27 = 0; n_rd1 = 0; last_rd27 = -1; min_gap27 = 1000000;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!psu_en && !mgmt_req, "R1", "psu/req in reset", {psu_en, mgmt_req}, 0);
        check(!sticky_powered && !sticky_link && !sticky_timeout, "R1", "stickies in reset",
              {sticky_powered, sticky_link, sticky_timeout}, 0);
        check(busy, "R1", "busy in reset", busy, 1);
        do_reset(16'h0000);
        for (int i = 0; i < 10 && !mgmt_req; i++) @(negedge clk);
        check(mgmt_req && !mgmt_we && mgmt_addr == 5'd0, "R1", "first transaction addr", mgmt_addr, 0);
    endtask

    task automatic t_init(input logic [15:0] reg0_init, input logic [15:0] exp_ctrl);
        do_reset(reg0_init);
        for (int i = 0; i < 200 && n_rd27 < 1; i++) @(negedge clk);
        check(wr_n >= 2 && wr_addr[0] == 5'd27 && wr_data[0] == 16'h0040, "R3", "discovery write",
              wr_data[0], 16'h0040);
        check(wr_addr[1] == 5'd0 && wr_data[1] == exp_ctrl, "R3", "control write", wr_data[1], exp_ctrl);
    endtask

    task automatic t_poll();
        for (int i = 0; i < 1000 && n_rd27 < 4; i++) @(negedge clk);
        check(n_rd27 >= 4, "R5", "flag reads repeat", n_rd27, 4);
        check(!psu_en, "R5", "psu off without flag", psu_en, 0);
        check(min_gap27 >= 20, "R5", "min poll spacing", min_gap27, 20);
        check(seen_idle && busy_err == 0, "R12", "busy low only while idle", busy_err, 0);
    endtask

    task automatic t_power_link();
        int mark;
        pd_flag = 1'b1;
        for (int i = 0; i < 200 && !psu_en; i++) @(negedge clk);
        check(psu_en && sticky_powered, "R6", "power on after flag", psu_en, 1);
        mark = wr_n;
        repeat (20) @(negedge clk);
        check(wr_n > mark && wr_addr[mark] == 5'd0 && wr_data[mark] == 16'h1200, "R6", "restart write",
              wr_data[mark], 16'h1200);
        repeat (40) @(negedge clk);
        link_now = 1'b1;
        for (int i = 0; i < 200 && !sticky_link; i++) @(negedge clk);
        check(sticky_link, "R7", "link confirmed", sticky_link, 1);
        check(n_rd1 % 2 == 0, "R7", "link taken from second read of pair", n_rd1 % 2, 0);
        while (cyc < rise_cyc + 600) @(negedge clk);
        check(psu_en && !sticky_timeout, "R8", "power kept with link", {psu_en, sticky_timeout}, 2);
    endtask

    task automatic t_drop();
        int mark, rd;
        pd_flag = 1'b0;
        mark = wr_n;
        link_now = 1'b0;
        for (int i = 0; i < 200 && psu_en; i++) @(negedge clk);
        check(!psu_en && !sticky_timeout, "R9", "power off on link loss", {psu_en, sticky_timeout}, 0);
        check(sticky_powered && sticky_link, "R11", "stickies survive drop", {sticky_powered, sticky_link}, 3);
        rd = n_rd27;
        for (int i = 0; i < 200 && n_rd27 == rd; i++) @(negedge clk);
        check(wr_n > mark && wr_addr[mark] == 5'd0 && wr_data[mark] == 16'h1200, "R10", "rearm write",
              wr_data[mark], 16'h1200);
        check(n_rd27 > rd, "R10", "flag polling resumes", n_rd27 - rd, 1);
    endtask

    task automatic t_timeout();
        int mark, dur;
        cfg_timeout = 32'd300;
        pd_flag = 1'b1;
        for (int i = 0; i < 200 && !psu_en; i++) @(negedge clk);
        mark = wr_n;
        pd_flag = 1'b0;
        for (int i = 0; i < 600 && psu_en; i++) @(negedge clk);
        dur = fall_cyc - rise_cyc;
        check(!psu_en && dur >= 300 && dur <= 380, "R8", "timeout window", dur, 300);
        check(sticky_timeout, "R8", "timeout flag", sticky_timeout, 1);
        repeat (20) @(negedge clk);
        check(wr_n >= mark + 2 && wr_data[mark + 1] == 16'h1200 && wr_addr[mark + 1] == 5'd0, "R10",
              "rearm after timeout", wr_data[mark + 1], 16'h1200);
        check(sticky_powered && sticky_link && sticky_timeout, "R11", "all stickies held", 7, 7);
    endtask

    task automatic t_forced();
        int mark;
        cfg_forced_mode = 1'b1;
        pd_flag = 1'b1;
        do_reset(m_reg0);
        for (int i = 0; i < 400 && !psu_en; i++) @(negedge clk);
        mark = wr_n;
        repeat (20) @(negedge clk);
        check(psu_en && wr_n > mark && wr_addr[mark] == 5'd0 && wr_data[mark] == 16'h2100, "R6",
              "forced-speed restart", wr_data[mark], 16'h2100);
        check(!sticky_timeout && !sticky_link, "R1", "reset cleared stickies", {sticky_link, sticky_timeout}, 0);
    endtask

    initial begin
        t_reset();
        t_init(16'h0000, 16'h1000);
        t_init(16'h1000, 16'h1200);
        t_poll();
        t_power_link();
        t_drop();
        t_timeout();
        t_forced();
        check(n_wr4 == 0, "R4", "register 4 never written", n_wr4, 0);
        check(hs_err == 0, "R2", "request held until done", hs_err, 0);
        check(sticky_err == 0, "R11", "no sticky flag cleared", sticky_err, 0);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule